// File: doc/BRIEF.md
# Selectable ADC Output Data Coder

This block sits between a 12-bit converter core and its output drivers. Each incoming sample arrives in offset binary with a valid strobe. The block recodes it into one of three output codings: offset binary (passed unchanged), two's complement, or Gray code. It registers the result, so the output appears exactly one clock cycle later together with its own valid flag.

The coding comes from one of two sources. By default a tri-level configuration pin selects it. A 3-bit override field, written through a simple write port, can take precedence over the pin. The field survives a soft reset and returns to pin control only on a hard reset. The coding is resolved when each sample is captured, so a change never splits a sample. A 2-bit status output reports which coding produced the word currently on the output.

Top module: `adc_out_coder`

## Requirements
- R1: A sample presented with `sampleValid` high at a clock edge, with no soft reset, appears on `dataOut` with `dataValid` high right after that edge. `dataValid` is low after any edge with no such sample.
- R2: Offset-binary coding passes the sample unchanged. It is reported as `fmtStatus` = 00.
- R3: Two's-complement coding inverts bit 11 of the sample and leaves bits 10..0 unchanged. It is reported as `fmtStatus` = 01.
- R4: Gray coding outputs `b ^ (b >> 1)` of the sample `b`. It is reported as `fmtStatus` = 10.
- R5: While the override field is 000, `pinFmt` selects the coding: 00 (pin low) gives two's complement, 01 (pin mid) gives Gray, 10 (pin high) gives offset binary, and 11 also gives offset binary.
- R6: Field value 001 forces two's complement, 010 forces Gray and 100 forces offset binary, whatever the pin level.
- R7: Field values 011, 101, 110 and 111 fall back to pin control, exactly as 000 does.
- R8: A field write updates the field at the edge where `regWrEn` is high. A sample captured at that same edge uses the old field value, and the next sample uses the new one.
- R9: A soft reset clears `dataOut` to 0 and drops `dataValid`, and a sample captured at that edge is dropped. The override field keeps its value, and a write made at the same edge still lands.
- R10: A hard reset (`rstHardN` low) clears `dataOut`, `dataValid` and `fmtStatus` to 0 and sets the field to 000 (pin control).
- R11: On edges with no captured sample and no reset, `dataOut` and `fmtStatus` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstHardN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous soft reset, active high |
| sampleIn | input | 12 | Converter sample, offset binary |
| sampleValid | input | 1 | Sample strobe |
| pinFmt | input | 2 | Resolved tri-level pin code: 00 low, 01 mid, 10 high |
| regWrEn | input | 1 | Override field write strobe |
| regWrData | input | 3 | Override field write value |
| dataOut | output | 12 | Recoded sample |
| dataValid | output | 1 | Output valid |
| fmtStatus | output | 2 | Coding of `dataOut`: 00 offset binary, 01 two's complement, 10 Gray |

## Verification
Two functions can land on the same edge in this block.

The first pair is a field write and a sample capture. The bench provokes this by asserting `regWrEn` and `sampleValid` together. It judges the result by expecting the old coding on that sample and the new coding on the following sample.

The second pair is a soft reset and a field write, or a soft reset and a sample. The bench expects the sample to be dropped and the output cleared, and it expects a later sample to show that the written field value was kept.

// File: rtl/adc_coder_pkg.sv
package adc_coder_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_GRAY   = 2'b10
  } fmt_e;

  typedef struct packed {
    logic load;
    logic clear;
    fmt_e fmt;
  } coder_ctrl_t;
endpackage

// File: rtl/coder_ctrl.sv
module coder_ctrl
  import adc_coder_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rstHardN,
  input  logic               softRst,
  input  logic               sampleValid,
  input  logic [1:0]         pinFmt,
  input  logic               regWrEn,
  input  logic [FIELD_W-1:0] regWrData,
  output coder_ctrl_t        ctrlStb
);
  localparam logic [FIELD_W-1:0] CODE_TWOS   = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] CODE_GRAY   = FIELD_W'(2);
  localparam logic [FIELD_W-1:0] CODE_OFFSET = FIELD_W'(4);

  logic [FIELD_W-1:0] fmtField;
  fmt_e pinChoice;
  fmt_e resolved;

  // override field: hard reset only, soft reset leaves it alone
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)    fmtField <= '0;
    else if (regWrEn) fmtField <= regWrData;
  end

  always_comb begin
    unique case (pinFmt)
      2'b00:   pinChoice = FMT_TWOS;
      2'b01:   pinChoice = FMT_GRAY;
      default: pinChoice = FMT_OFFSET;
    endcase
  end

  always_comb begin
    unique case (fmtField)
      CODE_TWOS:   resolved = FMT_TWOS;
      CODE_GRAY:   resolved = FMT_GRAY;
      CODE_OFFSET: resolved = FMT_OFFSET;
      default:     resolved = pinChoice;
    endcase
  end

  assign ctrlStb.load  = sampleValid & ~softRst;
  assign ctrlStb.clear = softRst;
  assign ctrlStb.fmt   = resolved;
endmodule

// File: rtl/coder_dpath.sv
module coder_dpath
  import adc_coder_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstHardN,
  input  coder_ctrl_t         ctrlStb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                dataValid,
  output fmt_e                fmtStatus
);
  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] twosWord;
  logic [SAMPLE_W-1:0] grayWord;
  logic [SAMPLE_W-1:0] codedWord;

  assign twosWord = {~sampleIn[MSB], sampleIn[MSB-1:0]};

  assign grayWord[MSB] = sampleIn[MSB];
  for (genvar i = 0; i < MSB; i++) begin : g_gray
    assign grayWord[i] = sampleIn[i] ^ sampleIn[i+1];
  end

  always_comb begin
    unique case (ctrlStb.fmt)
      FMT_TWOS: codedWord = twosWord;
      FMT_GRAY: codedWord = grayWord;
      default:  codedWord = sampleIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      fmtStatus <= FMT_OFFSET;
    end else if (ctrlStb.clear) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      fmtStatus <= FMT_OFFSET;
    end else begin
      dataValid <= ctrlStb.load;
      if (ctrlStb.load) begin
        dataOut   <= codedWord;
        fmtStatus <= ctrlStb.fmt;
      end
    end
  end
endmodule

// File: rtl/adc_out_coder.sv
module adc_out_coder
  import adc_coder_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FIELD_W  = 3
) (
  input  logic                clk,
  input  logic                rstHardN,
  input  logic                softRst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [1:0]          pinFmt,
  input  logic                regWrEn,
  input  logic [FIELD_W-1:0]  regWrData,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                dataValid,
  output logic [1:0]          fmtStatus
);
  coder_ctrl_t ctrlStb;
  fmt_e        fmtState;

  coder_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk(clk), .rstHardN(rstHardN), .softRst(softRst),
    .sampleValid(sampleValid), .pinFmt(pinFmt),
    .regWrEn(regWrEn), .regWrData(regWrData), .ctrlStb(ctrlStb)
  );

  coder_dpath #(.SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk(clk), .rstHardN(rstHardN), .ctrlStb(ctrlStb),
    .sampleIn(sampleIn), .dataOut(dataOut), .dataValid(dataValid),
    .fmtStatus(fmtState)
  );

  assign fmtStatus = fmtState;
endmodule

// File: rtl/adc_out_coder_chk.sv
module adc_out_coder_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rstHardN,
  input logic                softRst,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] dataOut,
  input logic                dataValid,
  input logic [1:0]          fmtStatus
);
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstHardN)
    (sampleValid && !softRst) |=> dataValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstHardN)
    (!sampleValid || softRst) |=> !dataValid);

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rstHardN)
    (sampleValid && !softRst) |=> (fmtStatus != 2'b00 || dataOut == $past(sampleIn)));

  a_r3_twos_msb: assert property (@(posedge clk) disable iff (!rstHardN)
    (sampleValid && !softRst) |=> (fmtStatus != 2'b01 || dataOut == ($past(sampleIn) ^ TOP_BIT)));

  a_r4_gray_word: assert property (@(posedge clk) disable iff (!rstHardN)
    (sampleValid && !softRst) |=>
      (fmtStatus != 2'b10 || dataOut == ($past(sampleIn) ^ ($past(sampleIn) >> 1))));

  a_r4_status_legal: assert property (@(posedge clk) disable iff (!rstHardN)
    fmtStatus != 2'b11);

  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rstHardN)
    softRst |=> (dataOut == '0 && !dataValid));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstHardN)
    (!sampleValid && !softRst) |=> ($stable(dataOut) && $stable(fmtStatus)));
endmodule

bind adc_out_coder adc_out_coder_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rstHardN(rstHardN), .softRst(softRst), .sampleIn(sampleIn),
  .sampleValid(sampleValid), .dataOut(dataOut), .dataValid(dataValid),
  .fmtStatus(fmtStatus)
);

// File: tb/tb_adc_out_coder.sv
module tb_adc_out_coder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rstHardN = 1'b0;
  logic softRst = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic sampleValid = 1'b0;
  logic [1:0] pinFmt = 2'b00;
  logic regWrEn = 1'b0;
  logic [2:0] regWrData = '0;
  logic [W-1:0] dataOut;
  logic dataValid;
  logic [1:0] fmtStatus;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_coder dut (
    .clk(clk), .rstHardN(rstHardN), .softRst(softRst), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .pinFmt(pinFmt), .regWrEn(regWrEn),
    .regWrData(regWrData), .dataOut(dataOut), .dataValid(dataValid),
    .fmtStatus(fmtStatus)
  );

  // coding ids: 0 offset, 1 twos, 2 gray
  function automatic logic [W-1:0] code(input int f, input logic [W-1:0] b);
    if (f == 1) return b ^ 12'h800;
    if (f == 2) return b ^ (b >> 1);
    return b;
  endfunction

  function automatic int pinCoding(input logic [1:0] p);
    if (p == 2'b00) return 1;
    if (p == 2'b01) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one edge's inputs, wait the edge, release them
  task automatic step(input logic v, input logic [W-1:0] s, input logic we,
                      input logic [2:0] wd, input logic sr);
    sampleValid = v; sampleIn = s; regWrEn = we; regWrData = wd; softRst = sr;
    @(posedge clk); #1;
    sampleValid = 1'b0; regWrEn = 1'b0; softRst = 1'b0;
  endtask

  task automatic sampleCheck(input string req, input logic [W-1:0] s, input int f);
    step(1'b1, s, 1'b0, 3'b000, 1'b0);
    chk(req, dataValid, 1);
    chk(req, dataOut, code(f, s));
    chk(req, fmtStatus, f);
  endtask

  task automatic hardReset();
    #1 rstHardN = 1'b0;
    #(CLK_PERIOD) rstHardN = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R10 reset dataValid", dataValid, 0);
    chk("R10 reset dataOut", dataOut, 0);
    chk("R10 reset fmtStatus", fmtStatus, 0);
  endtask

  task automatic t_pin();
    logic [W-1:0] pats [5] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hA5C};
    for (int p = 0; p < 4; p++) begin
      pinFmt = 2'(p);
      foreach (pats[i]) sampleCheck("R5 R2 R3 R4 pin coding", pats[i], pinCoding(2'(p)));
    end
  endtask

  task automatic t_latency();
    pinFmt = 2'b01;
    sampleCheck("R1 capture", 12'h3C7, 2);
    step(1'b0, 12'hFFF, 1'b0, 3'b000, 1'b0);
    chk("R1 valid drops", dataValid, 0);
    chk("R11 data holds", dataOut, code(2, 12'h3C7));
    pinFmt = 2'b10;
    step(1'b0, 12'h111, 1'b0, 3'b000, 1'b0);
    chk("R11 status holds", fmtStatus, 2);
  endtask

  task automatic t_override();
    logic [2:0] codes [3] = '{3'b001, 3'b010, 3'b100};
    int fs [3] = '{1, 2, 0};
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 3; p++) begin
        pinFmt = 2'(p);
        step(1'b0, '0, 1'b1, codes[c], 1'b0);
        sampleCheck("R6 override", 12'h9A3, fs[c]);
      end
    end
  endtask

  task automatic t_reserved();
    logic [2:0] codes [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
    foreach (codes[c]) begin
      for (int p = 0; p < 3; p++) begin
        pinFmt = 2'(p);
        step(1'b0, '0, 1'b1, codes[c], 1'b0);
        sampleCheck("R7 reserved falls to pin", 12'h6B4, pinCoding(2'(p)));
      end
    end
  endtask

  task automatic t_same_cycle();
    pinFmt = 2'b00;
    step(1'b0, '0, 1'b1, 3'b100, 1'b0);
    step(1'b1, 12'hC35, 1'b1, 3'b010, 1'b0);
    chk("R8 old coding on write edge", dataOut, code(0, 12'hC35));
    chk("R8 old status on write edge", fmtStatus, 0);
    sampleCheck("R8 new coding after write", 12'hC35, 2);
  endtask

  task automatic t_soft();
    pinFmt = 2'b01;
    step(1'b0, '0, 1'b1, 3'b001, 1'b0);
    sampleCheck("R9 before soft", 12'h0F0, 1);
    step(1'b1, 12'h555, 1'b0, 3'b000, 1'b1);
    chk("R9 soft drops valid", dataValid, 0);
    chk("R9 soft clears data", dataOut, 0);
    sampleCheck("R9 field kept", 12'h555, 1);
    step(1'b0, '0, 1'b1, 3'b100, 1'b1);
    sampleCheck("R9 write under soft lands", 12'h555, 0);
  endtask

  task automatic t_hard();
    pinFmt = 2'b01;
    step(1'b0, '0, 1'b1, 3'b001, 1'b0);
    sampleCheck("R10 pre", 12'h246, 1);
    hardReset();
    chk("R10 hard clears valid", dataValid, 0);
    chk("R10 hard clears data", dataOut, 0);
    sampleCheck("R10 field back to pin", 12'h246, 2);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 5) rstHardN = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_pin();
        t_latency();
        t_override();
        t_reserved();
        t_same_cycle();
        t_soft();
        t_hard();
      end
      begin
        #(CLK_PERIOD * 100000);
        nRun++; nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule